// File: doc/BRIEF.md
# Multicycle 16-bit Load/Store Processor Core

This block is a small multicycle processor for a 16-bit, word-addressed instruction set. It has eight general registers, a program counter and a three-flag condition code (negative, zero, positive). It runs every arithmetic, logic, load, store, branch, jump, subroutine and trap instruction. It talks to memory through one synchronous port. An address driven in one cycle returns its read data in the next cycle. A write takes a single cycle with the write enable held high.

A state machine sequences each instruction through its phases:

- `S_FETCH` drives the PC onto the address bus.
- `S_DECODE` captures the instruction word and increments the PC.
- `S_EXEC` does all register-only work and computes any memory address.
- `S_MADDR` and `S_MDATA` form one read: address cycle, then data cycle.
- `S_IADDR` and `S_IDATA` form the second read of an indirect load.
- `S_STORE` is the write cycle.
- `S_HALT` is the terminal state.

The transitions are:

- `S_FETCH` goes to `S_DECODE`, and `S_DECODE` goes to `S_EXEC`.
- `S_EXEC` returns to `S_FETCH` for ALU, LEA, branch, jump and subroutine instructions.
- `S_EXEC` goes to `S_MADDR` for loads, indirect stores and traps.
- `S_EXEC` goes to `S_STORE` for direct and base-relative stores.
- `S_EXEC` goes to `S_HALT` for the reserved opcode and for return-from-interrupt.
- `S_MADDR` goes to `S_MDATA`.
- `S_MDATA` goes to `S_IADDR` for an indirect load, to `S_STORE` for an indirect store, and to `S_FETCH` otherwise.
- `S_IADDR` goes to `S_IDATA`, and `S_IDATA` goes to `S_FETCH`.
- `S_STORE` goes to `S_FETCH`.
- `S_HALT` holds until reset.

Software runs by placing a program at the reset address and letting the core fetch it. An unsupported opcode stops the core and raises a flag, which also serves as a clean end-of-program marker.

Top module: `mc16_core`

## Requirements
- R1: After reset, the PC is x3000 and all eight registers are 0. The condition code output `cc_nzp` reads 3'b010; bit 2 is N, bit 1 is Z and bit 0 is P. `illegal_op` is low, and the first fetch address is x3000.
- R2: The opcode sits in bits 15:12. ADD=0001 and AND=0101 write DR (bits 11:9) with SR1 (bits 8:6) combined with a second operand. When bit 5 is 1, that operand is the sign-extended imm5 in bits 4:0; when bit 5 is 0, it is the register in bits 2:0. NOT=1001 writes the bitwise complement of SR1.
- R3: ADD, AND, NOT, LD, LDI, LDR and LEA set exactly one of N/Z/P from the value written to DR. ST, STI and STR leave the flags unchanged.
- R4: BR=0000 with flags n,z,p in bits 11:9 is taken when (n&N)|(z&Z)|(p&P). The target is the incremented PC plus the sign-extended offset in bits 8:0.
- R5: LD=0010 loads and ST=0011 stores at the incremented PC plus the sign-extended 9-bit offset. LEA=1110 writes that address itself into DR.
- R6: LDR=0110 and STR=0111 address memory at the base register (bits 8:6) plus the sign-extended 6-bit offset in bits 5:0.
- R7: LDI=1010 and STI=1011 first read a pointer at the incremented PC plus offset9, then load from or store to the pointed-to word.
- R8: JMP=1100 loads the PC from the base register in bits 8:6. With base 7 this is the subroutine return.
- R9: JSR (opcode 0100, bit 11=1) writes the incremented PC to R7 and jumps by the sign-extended offset in bits 10:0. JSRR (bit 11=0) jumps to the base register, read before R7 is overwritten.
- R10: TRAP=1111 writes the incremented PC to R7 and loads the PC from memory at the zero-extended 8-bit vector in bits 7:0.
- R11: Opcode 1101 and RTI=1000 set `illegal_op`, which stays high until reset. The core then fetches no further instructions and makes no further writes.
- R12: Read data is taken from `mem_rdata` one cycle after its address is driven. A store is a single cycle with `mem_we` high, followed by a cycle with it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Store data |
| mem_we | output | 1 | Write enable for the current cycle |
| mem_rdata | input | 16 | Read data for the address of the previous cycle |
| cc_nzp | output | 3 | Condition codes {N,Z,P} |
| illegal_op | output | 1 | Core halted on an unsupported opcode |

## Verification
The assertions assume the memory returns read data exactly one cycle after the address and never stalls. They also assume reset is held for at least one clock edge before the first fetch. The bench memory model is a registered read with a same-edge write, so it meets that timing by construction. Every program the bench loads ends in an unsupported opcode, so each run stops in the halt state. Random operands and immediates come from a fixed seed and include the sign-boundary values, so the flag and sign-extension paths are exercised without depending on the order of instructions.

// File: rtl/mc16_pkg.sv
package mc16_pkg;

    localparam int unsigned WORD_W = 16;

    typedef enum logic [3:0] {
        OP_BR   = 4'b0000,
        OP_ADD  = 4'b0001,
        OP_LD   = 4'b0010,
        OP_ST   = 4'b0011,
        OP_JSR  = 4'b0100,
        OP_AND  = 4'b0101,
        OP_LDR  = 4'b0110,
        OP_STR  = 4'b0111,
        OP_RTI  = 4'b1000,
        OP_NOT  = 4'b1001,
        OP_LDI  = 4'b1010,
        OP_STI  = 4'b1011,
        OP_JMP  = 4'b1100,
        OP_RSV  = 4'b1101,
        OP_LEA  = 4'b1110,
        OP_TRAP = 4'b1111
    } opcode_e;

    typedef enum logic [3:0] {
        S_FETCH,
        S_DECODE,
        S_EXEC,
        S_MADDR,
        S_MDATA,
        S_IADDR,
        S_IDATA,
        S_STORE,
        S_HALT
    } state_e;

    // Flags derived from a written value: {N, Z, P}
    function automatic logic [2:0] flags_of(input logic [WORD_W-1:0] v);
        if (v[WORD_W-1])
            return 3'b100;
        else if (v == '0)
            return 3'b010;
        else
            return 3'b001;
    endfunction

endpackage

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned NREGS  = 8,
    localparam int unsigned AW    = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     sel_a,
    output logic [WORD_W-1:0] val_a,
    input  logic [AW-1:0]     sel_b,
    output logic [WORD_W-1:0] val_b,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_sel,
    input  logic [WORD_W-1:0] wr_val
);

    logic [WORD_W-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[wr_sel] <= wr_val;
        end
    end

    // Combinational reads return the value held before this cycle's write
    assign val_a = regs[sel_a];
    assign val_b = regs[sel_b];

endmodule

// File: rtl/mc16_alu.sv
module mc16_alu
    import mc16_pkg::*;
(
    input  opcode_e           op,
    input  logic              use_imm,
    input  logic [4:0]        imm5,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [WORD_W-1:0] y
);

    logic [WORD_W-1:0] opnd;

    always_comb begin
        opnd = use_imm ? {{(WORD_W-5){imm5[4]}}, imm5} : b;
        case (op)
            OP_ADD:  y = a + opnd;
            OP_AND:  y = a & opnd;
            default: y = ~a;
        endcase
    end

endmodule

// File: rtl/mc16_core.sv
module mc16_core
    import mc16_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h3000
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    output logic        mem_we,
    input  logic [15:0] mem_rdata,
    output logic [2:0]  cc_nzp,
    output logic        illegal_op
);

    localparam int unsigned NREGS   = 8;
    localparam int unsigned RA_W    = $clog2(NREGS);
    localparam logic [RA_W-1:0] LINK_REG = RA_W'(NREGS - 1);

    state_e            state_q, state_d;
    logic [WORD_W-1:0] pc_q, ir_q, maddr_q;
    logic [2:0]        cc_q;

    opcode_e           op;
    logic [RA_W-1:0]   dst, src1, sel_b;
    logic [WORD_W-1:0] off9, off11, off6, pc_rel, base_rel;
    logic [WORD_W-1:0] val_a, val_b, alu_y;
    logic              br_go;

    logic              rf_we, cc_we;
    logic [RA_W-1:0]   rf_wa;
    logic [WORD_W-1:0] rf_wd;

    assign op       = opcode_e'(ir_q[15:12]);
    assign dst      = ir_q[11:9];
    assign src1     = ir_q[8:6];
    assign off9     = {{(WORD_W-9){ir_q[8]}}, ir_q[8:0]};
    assign off11    = {{(WORD_W-11){ir_q[10]}}, ir_q[10:0]};
    assign off6     = {{(WORD_W-6){ir_q[5]}}, ir_q[5:0]};
    assign pc_rel   = pc_q + off9;
    assign base_rel = val_a + off6;
    assign br_go    = |(ir_q[11:9] & cc_q);
    assign sel_b    = (state_q == S_STORE) ? dst : ir_q[2:0];

    mc16_regfile #(.WORD_W(WORD_W), .NREGS(NREGS)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_a  (src1),
        .val_a  (val_a),
        .sel_b  (sel_b),
        .val_b  (val_b),
        .wr_en  (rf_we),
        .wr_sel (rf_wa),
        .wr_val (rf_wd)
    );

    mc16_alu u_alu (
        .op      (op),
        .use_imm (ir_q[5]),
        .imm5    (ir_q[4:0]),
        .a       (val_a),
        .b       (val_b),
        .y       (alu_y)
    );

    // State register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_FETCH;
            pc_q    <= RESET_PC;
            ir_q    <= '0;
            maddr_q <= '0;
            cc_q    <= 3'b010;
        end else begin
            state_q <= state_d;
            if (cc_we) cc_q <= flags_of(rf_wd);
            case (state_q)
                S_DECODE: begin
                    ir_q <= mem_rdata;
                    pc_q <= pc_q + 16'd1;
                end
                S_EXEC: begin
                    case (op)
                        OP_BR:   if (br_go) pc_q <= pc_rel;
                        OP_JMP:  pc_q <= val_a;
                        OP_JSR:  pc_q <= ir_q[11] ? (pc_q + off11) : val_a;
                        OP_LD, OP_LDI, OP_ST, OP_STI: maddr_q <= pc_rel;
                        OP_LDR, OP_STR: maddr_q <= base_rel;
                        OP_TRAP: maddr_q <= {8'h00, ir_q[7:0]};
                        default: ;
                    endcase
                end
                S_MDATA: begin
                    if (op == OP_TRAP)
                        pc_q <= mem_rdata;
                    else if (op == OP_LDI || op == OP_STI)
                        maddr_q <= mem_rdata;
                end
                default: ;
            endcase
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FETCH:  state_d = S_DECODE;
            S_DECODE: state_d = S_EXEC;
            S_EXEC: begin
                case (op)
                    OP_LD, OP_LDR, OP_LDI, OP_STI, OP_TRAP: state_d = S_MADDR;
                    OP_ST, OP_STR:  state_d = S_STORE;
                    OP_RTI, OP_RSV: state_d = S_HALT;
                    default:        state_d = S_FETCH;
                endcase
            end
            S_MADDR: state_d = S_MDATA;
            S_MDATA: begin
                if (op == OP_LDI)      state_d = S_IADDR;
                else if (op == OP_STI) state_d = S_STORE;
                else                   state_d = S_FETCH;
            end
            S_IADDR: state_d = S_IDATA;
            S_IDATA: state_d = S_FETCH;
            S_STORE: state_d = S_FETCH;
            S_HALT:  state_d = S_HALT;
            default: state_d = S_HALT;
        endcase
    end

    // Outputs: memory port, register write port, flag update
    always_comb begin
        mem_addr   = (state_q == S_FETCH) ? pc_q : maddr_q;
        mem_we     = (state_q == S_STORE);
        mem_wdata  = val_b;
        illegal_op = (state_q == S_HALT);
        rf_we      = 1'b0;
        rf_wa      = dst;
        rf_wd      = alu_y;
        cc_we      = 1'b0;
        case (state_q)
            S_EXEC: begin
                case (op)
                    OP_ADD, OP_AND, OP_NOT: begin
                        rf_we = 1'b1;
                        cc_we = 1'b1;
                    end
                    OP_LEA: begin
                        rf_we = 1'b1;
                        rf_wd = pc_rel;
                        cc_we = 1'b1;
                    end
                    OP_JSR, OP_TRAP: begin
                        rf_we = 1'b1;
                        rf_wa = LINK_REG;
                        rf_wd = pc_q;
                    end
                    default: ;
                endcase
            end
            S_MDATA: begin
                if (op == OP_LD || op == OP_LDR) begin
                    rf_we = 1'b1;
                    rf_wd = mem_rdata;
                    cc_we = 1'b1;
                end
            end
            S_IDATA: begin
                rf_we = 1'b1;
                rf_wd = mem_rdata;
                cc_we = 1'b1;
            end
            default: ;
        endcase
    end

    assign cc_nzp = cc_q;

    // R3: exactly one flag is ever set
    a_r3_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cc_nzp) == 1);

    // R3: a store cycle never disturbs the flags
    a_r3_store_keeps_cc: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> $stable(cc_nzp));

    // R11: the halt flag is sticky
    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |=> illegal_op);

    // R11: no memory writes once halted
    a_r11_no_write_halted: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> !mem_we);

    // R12: a store lasts exactly one cycle
    a_r12_store_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

endmodule

// File: tb/mc16_core_tb_top.sv
`timescale 1ns/1ps
module mc16_core_tb_top;

    localparam logic [3:0] K_ADD = 4'b0001, K_AND = 4'b0101, K_LD = 4'b0010,
                           K_ST = 4'b0011, K_LDR = 4'b0110, K_STR = 4'b0111,
                           K_LDI = 4'b1010, K_STI = 4'b1011, K_LEA = 4'b1110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we, illegal_op;
    logic [2:0]  cc_nzp;

    logic [15:0] mem [0:4095];
    int checks = 0;
    int errors = 0;
    int halted_writes = 0;
    int at;

    always #2.5 clk = ~clk;

    mc16_core dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we),
        .mem_rdata  (mem_rdata),
        .cc_nzp     (cc_nzp),
        .illegal_op (illegal_op)
    );

    // Memory model: registered read, one-cycle latency
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[11:0]];
        if (rst_n && illegal_op && mem_we) halted_writes++;
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_flags(input logic [15:0] v);
        return v[15] ? 3'b100 : (v == 16'h0 ? 3'b010 : 3'b001);
    endfunction

    function automatic logic [15:0] sx5(input logic [4:0] v);
        return {{11{v[4]}}, v};
    endfunction

    // Instruction encoders
    function automatic logic [15:0] e_rr(input logic [3:0] op, input int d, input int s, input int t);
        return {op, 3'(d), 3'(s), 3'b000, 3'(t)};
    endfunction
    function automatic logic [15:0] e_ri(input logic [3:0] op, input int d, input int s, input logic [4:0] imm);
        return {op, 3'(d), 3'(s), 1'b1, imm};
    endfunction
    function automatic logic [15:0] e_not(input int d, input int s);
        return {4'b1001, 3'(d), 3'(s), 6'b111111};
    endfunction
    function automatic logic [15:0] e_pc(input logic [3:0] op, input int r, input int here, input int target);
        return {op, 3'(r), 9'(target - (here + 1))};
    endfunction
    function automatic logic [15:0] e_br(input logic [2:0] nzp, input int here, input int target);
        return {4'b0000, nzp, 9'(target - (here + 1))};
    endfunction
    function automatic logic [15:0] e_base(input logic [3:0] op, input int r, input int b, input int off);
        return {op, 3'(r), 3'(b), 6'(off)};
    endfunction
    function automatic logic [15:0] e_jsr(input int here, input int target);
        return {4'b0100, 1'b1, 11'(target - (here + 1))};
    endfunction
    function automatic logic [15:0] e_jsrr(input int b);
        return {4'b0100, 3'b000, 3'(b), 6'b0};
    endfunction
    function automatic logic [15:0] e_jmp(input int b);
        return {4'b1100, 3'b000, 3'(b), 6'b0};
    endfunction
    function automatic logic [15:0] e_trap(input logic [7:0] v);
        return {8'hF0, v};
    endfunction

    task automatic put(input int a, input logic [15:0] w);
        mem[a & 12'hFFF] = w;
    endtask
    task automatic emit(input logic [15:0] w);
        put(at, w);
        at++;
    endtask
    task automatic clear_mem;
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0;
    endtask
    function automatic logic [15:0] rd(input int a);
        return mem[a & 12'hFFF];
    endfunction

    task automatic run_prog;
        bit done;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        done = 1'b0;
        for (int i = 0; i < 4000 && !done; i++) begin
            @(negedge clk);
            if (illegal_op) done = 1'b1;
        end
        repeat (20) @(negedge clk);
        chk("R11 program reached halt", 16'(done), 16'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] a, b, r;
        logic [4:0]  i1, i2;
        int jsr_ret, jsrr_ret, trap_ret, loop_at;
        void'($urandom(32'd5171));

        // ---- R1: reset state and reset register contents ----
        clear_mem();
        for (int i = 0; i < 8; i++) put(16'h3040 + i, 16'hAAAA);
        at = 16'h3000;
        for (int i = 0; i < 8; i++) emit(e_pc(K_ST, i, at, 16'h3040 + i));
        emit(16'hD000);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 first fetch address", mem_addr, 16'h3000);
        chk("R1 flags after reset", 16'(cc_nzp), 16'h0002);
        chk("R1 illegal_op low", 16'(illegal_op), 16'h0);
        chk("R1 no write in reset", 16'(mem_we), 16'h0);
        run_prog();
        for (int i = 0; i < 8; i++) chk("R1 register reset to zero", rd(16'h3040 + i), 16'h0);
        chk("R3 stores keep reset flags", 16'(cc_nzp), 16'h0002);

        // ---- Directed program covering control flow and addressing ----
        clear_mem();
        put(16'h3040, 16'd7);
        put(16'h3041, 16'd5);
        put(16'h3043, 16'h3052);
        put(16'h3044, 16'h3056);
        put(16'h3045, 16'h8000);
        put(16'h3052, 16'h1234);
        put(16'h0025, 16'h3038);
        at = 16'h3000;
        emit(e_pc(K_LD, 0, at, 16'h3040));
        emit(e_pc(K_LD, 1, at, 16'h3041));
        emit(e_ri(K_AND, 2, 2, 5'd0));
        loop_at = at;
        emit(e_rr(K_ADD, 2, 2, 0));
        emit(e_ri(K_ADD, 1, 1, 5'h1F));
        emit(e_br(3'b001, at, loop_at));
        emit(e_pc(K_ST, 2, at, 16'h3042));
        emit(e_pc(K_LEA, 3, at, 16'h3050));
        emit(e_base(K_LDR, 4, 3, 2));
        emit(e_base(K_STR, 4, 3, 5));
        emit(e_pc(K_LDI, 5, at, 16'h3043));
        emit(e_ri(K_ADD, 5, 5, 5'd1));
        emit(e_pc(K_STI, 5, at, 16'h3044));
        emit(e_pc(K_LD, 6, at, 16'h3045));
        emit(e_pc(K_ST, 6, at, 16'h3046));
        emit(e_br(3'b100, at, at + 2));
        emit(e_ri(K_ADD, 6, 6, 5'd1));
        emit(e_pc(K_ST, 6, at, 16'h3047));
        jsr_ret = at + 1;
        emit(e_jsr(at, 16'h3030));
        emit(e_pc(K_ST, 0, at, 16'h3048));
        emit(e_pc(K_ST, 7, at, 16'h3049));
        emit(e_pc(K_LEA, 1, at, 16'h3034));
        jsrr_ret = at + 1;
        emit(e_jsrr(1));
        trap_ret = at + 1;
        emit(e_trap(8'h25));
        emit(e_not(0, 0));
        emit(e_pc(K_ST, 0, at, 16'h304C));
        emit(e_ri(K_AND, 1, 1, 5'd0));
        emit(e_pc(K_LEA, 2, at, at + 3));
        emit(e_jmp(2));
        emit(e_ri(K_ADD, 1, 1, 5'd1));
        emit(e_pc(K_ST, 1, at, 16'h304D));
        emit(16'hD000);
        at = 16'h3030;
        emit(e_ri(K_ADD, 0, 0, 5'd3));
        emit(e_jmp(7));
        at = 16'h3034;
        emit(e_pc(K_ST, 7, at, 16'h304A));
        emit(e_jmp(7));
        at = 16'h3038;
        emit(e_pc(K_ST, 7, at, 16'h304B));
        emit(e_jmp(7));
        run_prog();
        chk("R4 loop product via taken/untaken BR", rd(16'h3042), 16'd35);
        chk("R6 LDR then STR base+offset", rd(16'h3055), 16'h1234);
        chk("R7 LDI/STI two-level access (R12 timing)", rd(16'h3056), 16'h1235);
        chk("R5 LD/ST PC-relative", rd(16'h3046), 16'h8000);
        chk("R3 BRn taken after store kept N", rd(16'h3047), 16'h8000);
        chk("R9 JSR subroutine effect", rd(16'h3048), 16'h000A);
        chk("R9 JSR link value", rd(16'h3049), 16'(jsr_ret));
        chk("R9 JSRR link value", rd(16'h304A), 16'(jsrr_ret));
        chk("R10 TRAP vector and link", rd(16'h304B), 16'(trap_ret));
        chk("R2 NOT result", rd(16'h304C), 16'hFFF5);
        chk("R8 JMP skipped instruction", rd(16'h304D), 16'h0000);
        chk("R5 LEA set P flag", 16'(cc_nzp), 16'h0001);
        chk("R11 halted after reserved opcode", 16'(illegal_op), 16'h1);

        // ---- Random ALU and flag runs ----
        for (int k = 0; k < 24; k++) begin
            a  = 16'($urandom);
            b  = 16'($urandom);
            i1 = 5'($urandom);
            i2 = 5'($urandom);
            if (k == 0) begin a = 16'h0000; b = 16'h0000; i1 = 5'h10; end
            if (k == 1) begin a = 16'h7FFF; b = 16'h0001; i1 = 5'h01; end
            if (k == 2) begin a = 16'h8000; b = 16'hFFFF; i2 = 5'h0F; end
            clear_mem();
            put(16'h3040, a);
            put(16'h3041, b);
            at = 16'h3000;
            emit(e_pc(K_LD, 1, at, 16'h3040));
            emit(e_pc(K_LD, 2, at, 16'h3041));
            emit(e_rr(K_ADD, 3, 1, 2));
            emit(e_rr(K_AND, 4, 1, 2));
            emit(e_ri(K_ADD, 5, 1, i1));
            emit(e_ri(K_AND, 6, 2, i2));
            emit(e_not(0, 1));
            emit(e_pc(K_ST, 3, at, 16'h3042));
            emit(e_pc(K_ST, 4, at, 16'h3043));
            emit(e_pc(K_ST, 5, at, 16'h3044));
            emit(e_pc(K_ST, 6, at, 16'h3045));
            emit(e_pc(K_ST, 0, at, 16'h3046));
            emit(e_ri(K_ADD, 7, 2, 5'd0));
            emit(16'hD000);
            run_prog();
            r = a + b;
            chk("R2 ADD register mode", rd(16'h3042), r);
            chk("R2 AND register mode", rd(16'h3043), a & b);
            chk("R2 ADD immediate mode", rd(16'h3044), a + sx5(i1));
            chk("R2 AND immediate mode", rd(16'h3045), b & sx5(i2));
            chk("R2 NOT", rd(16'h3046), ~a);
            chk("R3 flags from last write", 16'(cc_nzp), 16'(exp_flags(b)));
        end

        // ---- R11: RTI halts and the following store never happens ----
        clear_mem();
        put(16'h3040, 16'hBEEF);
        at = 16'h3000;
        emit(16'h8000);
        emit(e_pc(K_ST, 0, at, 16'h3040));
        run_prog();
        chk("R11 RTI raises illegal_op", 16'(illegal_op), 16'h1);
        chk("R11 no store after RTI", rd(16'h3040), 16'hBEEF);
        chk("R11 no writes while halted", 16'(halted_writes), 16'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule